// File: doc/BRIEF.md
# Log-domain max-star butterfly

This block is the arithmetic core of one trellis butterfly in a soft-output, log-domain MAP decoder. On every cycle it can accept a pair of state metrics and one branch metric. From them it forms four candidate path metrics and reduces them pairwise to two updated state metrics. Each reduction is a max-star: the larger candidate, plus a small correction read from a table. The table is indexed by how far apart the two candidates are.

A per-beat mode bit selects between the full log-MAP approximation, which applies the correction, and the cheaper max-log approximation, which uses the plain maximum. The result comes out a fixed three cycles after the beat goes in, with a valid flag beside it. A recursion controller can therefore stream one butterfly per cycle with no back-pressure. Sequencing the alpha/beta recursions, computing branch metrics, windowing and extrinsic output all stay outside this block.

Top module: `mstar_butterfly`

## Requirements
- R1: `out_valid` is high in the cycle exactly three rising edges after `in_valid` was sampled high, and low otherwise. While `in_valid` is low, the metric and mode inputs have no effect on any output beat.
- R2: With a = `metric_a`, b = `metric_b`, x = `branch` (signed 16-bit), `out_0` = max*(a+x, b-x).
- R3: `out_1` = max*(b+x, a-x), computed from the same beat as `out_0`.
- R4: With `in_full_mode` = 1, max*(p,q) = max(p,q) + T[|p-q| div 4]. T is an unsigned table of 3-fractional-bit constants. Its default contents for index 0..7 are 6, 4, 3, 2, 1, 1, 0, 0.
- R5: When |p-q| div 4 is 8 or more (past the last table entry), the correction is zero. At the table edge, |p-q| = 23 still adds 1 and |p-q| = 24 adds 0.
- R6: With `in_full_mode` = 0, max*(p,q) = max(p,q) exactly, with no correction.
- R7: A result above 32767 is clamped to 32767. This covers both a large candidate and a correction pushing a 32767 maximum over the limit.
- R8: While `rst_n` is low at a rising edge, the pipeline is cleared. `out_valid` is low after reset, and beats in flight when reset arrives are never delivered.
- R9: Beats may arrive on consecutive cycles. Each beat keeps its own mode bit through the pipeline, so alternating modes on back-to-back beats give per-beat results.
- R10: Equal candidates (p = q) receive the largest correction, T[0] = 6, in full mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A butterfly beat is presented this cycle |
| in_full_mode | input | 1 | 1 = log-MAP with correction, 0 = max-log |
| metric_a | input | 16 | First source state metric, signed |
| metric_b | input | 16 | Second source state metric, signed |
| branch | input | 16 | Branch metric, signed |
| out_valid | output | 1 | Results of a beat are present |
| out_0 | output | 16 | Updated metric max*(a+x, b-x), signed |
| out_1 | output | 16 | Updated metric max*(b+x, a-x), signed |

## Verification
Directed beats target the correction table. Equal candidates pick out entry zero. Differences of 23 and 24 sit on either side of the last non-zero entry, and large differences must get no correction at all. Identical inputs sent in both modes show whether the mode bit actually gates the correction. Near-full-scale metrics show whether the clamp triggers on the candidate sum and on the correction alone. Random beats with small metrics land inside the table range, where a wrong index shift or a wrong lane pairing (a+x against b-x rather than a-x) shows up. Random full-range beats and gaps in `in_valid` exercise the sign handling and the three-cycle alignment of outputs with their beats.

// File: rtl/mstar_pkg.sv
// Package: shared definitions for the max-star butterfly.
// Assumes: metrics are two's complement; mode bit 1 means log-MAP.
package mstar_pkg;

    // Approximation applied by a lane's final stage
    typedef enum logic {
        MODE_MAXLOG = 1'b0,
        MODE_LOGMAP = 1'b1
    } mstar_mode_e;

    // Number of output lanes of one butterfly
    localparam int LANES = 2;

    // Number of register stages from input to output
    localparam int STAGES = 3;

endpackage

// File: rtl/mstar_vpipe.sv
// Module: mstar_vpipe
// Carries the valid flag and the mode bit of each beat alongside the
// data stages. Bit i of the outputs belongs to the beat held in stage i+1.
// Assumes: DEPTH >= 2; reset clears every valid flag.
module mstar_vpipe #(
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_mode,
    output logic [DEPTH-1:0] stage_valid,
    output logic [DEPTH-1:0] stage_mode
);

    // First stage captures the beat flags from the block inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_valid[0] <= 1'b0;
            stage_mode[0]  <= 1'b0;
        end else begin
            stage_valid[0] <= in_valid;
            stage_mode[0]  <= in_valid ? in_mode : stage_mode[0];
        end
    end

    // Later stages shift the flags one step per cycle
    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_valid[i] <= 1'b0;
                stage_mode[i]  <= 1'b0;
            end else begin
                stage_valid[i] <= stage_valid[i-1];
                stage_mode[i]  <= stage_valid[i-1] ? stage_mode[i-1] : stage_mode[i];
            end
        end
    end

endmodule

// File: rtl/mstar_cand.sv
// Module: mstar_cand
// Stage 1: forms the four candidates a+x, b+x, a-x, b-x one bit wider
// than the metrics, so no overflow occurs. Lane 0 pairs a+x with b-x;
// lane 1 pairs b+x with a-x.
// Assumes: inputs are W-bit signed; registers load only on a valid beat.
module mstar_cand
    import mstar_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic signed [W-1:0] met_a,
    input  logic signed [W-1:0] met_b,
    input  logic signed [W-1:0] met_x,
    output logic signed [W:0]   cand_p [LANES],
    output logic signed [W:0]   cand_q [LANES]
);

    logic signed [W:0] ext_a;
    logic signed [W:0] ext_b;
    logic signed [W:0] ext_x;

    // Sign-extend the operands to the candidate width
    always_comb begin
        ext_a = {met_a[W-1], met_a};
        ext_b = {met_b[W-1], met_b};
        ext_x = {met_x[W-1], met_x};
    end

    // Register the four sums and differences in their lane order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < LANES; l++) begin
                cand_p[l] <= '0;
                cand_q[l] <= '0;
            end
        end else if (en) begin
            cand_p[0] <= ext_a + ext_x;
            cand_q[0] <= ext_b - ext_x;
            cand_p[1] <= ext_b + ext_x;
            cand_q[1] <= ext_a - ext_x;
        end
    end

endmodule

// File: rtl/mstar_cmp.sv
// Module: mstar_cmp
// Stage 2 of one lane: picks the larger of two candidates and keeps the
// magnitude of their difference for the correction lookup.
// Assumes: candidates are W+1-bit signed; the difference needs W+2 bits.
module mstar_cmp #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic signed [W:0]   cand_p,
    input  logic signed [W:0]   cand_q,
    output logic signed [W:0]   larger,
    output logic        [W+1:0] gap
);

    logic signed [W+1:0] diff;
    logic        [W+1:0] diff_mag;

    // Signed difference and its absolute value
    always_comb begin
        diff     = {cand_p[W], cand_p} - {cand_q[W], cand_q};
        diff_mag = diff[W+1] ? $unsigned(-diff) : $unsigned(diff);
    end

    // Register the maximum and the gap for stage 3
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            larger <= '0;
            gap    <= '0;
        end else if (en) begin
            larger <= diff[W+1] ? cand_q : cand_p;
            gap    <= diff_mag;
        end
    end

endmodule

// File: rtl/mstar_corr.sv
// Module: mstar_corr
// Stage 3 of one lane: reads the correction for the candidate gap, adds
// it to the maximum when log-MAP is selected, and clamps to W bits.
// Assumes: table entry i sits at bits [i*CORR_W +: CORR_W] of CORR_TABLE;
// a gap indexing past TBL_DEPTH-1 receives no correction.
module mstar_corr #(
    parameter int                       W          = 16,
    parameter int                       CORR_W     = 4,
    parameter int                       TBL_DEPTH  = 8,
    parameter int                       IDX_SHIFT  = 2,
    parameter logic [TBL_DEPTH*CORR_W-1:0] CORR_TABLE = 32'h0011_2346
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                use_corr,
    input  logic signed [W:0]   larger,
    input  logic        [W+1:0] gap,
    output logic signed [W-1:0] result
);

    localparam int IDXW = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1;
    localparam int SW   = W + 2;
    localparam logic signed [SW-1:0] SAT_HI = {3'b000, {(W-1){1'b1}}};
    localparam logic signed [SW-1:0] SAT_LO = {3'b111, {(W-1){1'b0}}};

    logic [CORR_W-1:0] tbl [TBL_DEPTH];
    logic [SW-1:0]     step_idx;
    logic              in_range;
    logic [IDXW-1:0]   idx;
    logic [CORR_W-1:0] corr;
    logic signed [SW-1:0] total;
    logic signed [W-1:0]  clamped;

    // Unpack the table parameter into one entry per index
    for (genvar i = 0; i < TBL_DEPTH; i++) begin : g_tbl
        assign tbl[i] = CORR_TABLE[i*CORR_W +: CORR_W];
    end

    // Quantise the gap to a table index and read the correction
    always_comb begin
        step_idx = gap >> IDX_SHIFT;
        in_range = step_idx < SW'(TBL_DEPTH);
        idx      = step_idx[IDXW-1:0];
        corr     = (in_range && use_corr) ? tbl[idx] : '0;
    end

    // Add the correction in a widened sum and clamp to W bits
    always_comb begin
        total = {larger[W], larger} + {{(SW-CORR_W){1'b0}}, corr};
        if (total > SAT_HI) begin
            clamped = SAT_HI[W-1:0];
        end else if (total < SAT_LO) begin
            clamped = SAT_LO[W-1:0];
        end else begin
            clamped = total[W-1:0];
        end
    end

    // Output register of the lane
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (en) begin
            result <= clamped;
        end
    end

endmodule

// File: rtl/mstar_butterfly.sv
// Module: mstar_butterfly
// Three-stage max-star butterfly: candidates, compare, correct-and-clamp.
// One beat per cycle, fixed latency of STAGES cycles.
// Assumes: in_full_mode is sampled with in_valid and travels with its beat.
module mstar_butterfly
    import mstar_pkg::*;
#(
    parameter int                          METRIC_W   = 16,
    parameter int                          CORR_W     = 4,
    parameter int                          TBL_DEPTH  = 8,
    parameter int                          IDX_SHIFT  = 2,
    parameter logic [TBL_DEPTH*CORR_W-1:0] CORR_TABLE = 32'h0011_2346
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic                       in_full_mode,
    input  logic signed [METRIC_W-1:0] metric_a,
    input  logic signed [METRIC_W-1:0] metric_b,
    input  logic signed [METRIC_W-1:0] branch,
    output logic                       out_valid,
    output logic signed [METRIC_W-1:0] out_0,
    output logic signed [METRIC_W-1:0] out_1
);

    logic [STAGES-1:0]          st_valid;
    logic [STAGES-1:0]          st_mode;
    logic signed [METRIC_W:0]   cand_p [LANES];
    logic signed [METRIC_W:0]   cand_q [LANES];
    logic signed [METRIC_W:0]   lane_max [LANES];
    logic        [METRIC_W+1:0] lane_gap [LANES];
    logic signed [METRIC_W-1:0] lane_res [LANES];
    mstar_mode_e                stage3_mode;

    // Valid and mode flags travelling with each beat
    mstar_vpipe #(.DEPTH(STAGES)) i_vpipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_mode     (in_full_mode),
        .stage_valid (st_valid),
        .stage_mode  (st_mode)
    );

    // Stage 1: candidate sums and differences
    mstar_cand #(.W(METRIC_W)) i_cand (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (in_valid),
        .met_a  (metric_a),
        .met_b  (metric_b),
        .met_x  (branch),
        .cand_p (cand_p),
        .cand_q (cand_q)
    );

    // Mode of the beat entering stage 3
    assign stage3_mode = mstar_mode_e'(st_mode[1]);

    // Stages 2 and 3, one copy per output lane
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        mstar_cmp #(.W(METRIC_W)) i_cmp (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (st_valid[0]),
            .cand_p (cand_p[l]),
            .cand_q (cand_q[l]),
            .larger (lane_max[l]),
            .gap    (lane_gap[l])
        );

        mstar_corr #(
            .W          (METRIC_W),
            .CORR_W     (CORR_W),
            .TBL_DEPTH  (TBL_DEPTH),
            .IDX_SHIFT  (IDX_SHIFT),
            .CORR_TABLE (CORR_TABLE)
        ) i_corr (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (st_valid[1]),
            .use_corr (stage3_mode == MODE_LOGMAP),
            .larger   (lane_max[l]),
            .gap      (lane_gap[l]),
            .result   (lane_res[l])
        );
    end

    // Drive the ports from the last stage
    assign out_valid = st_valid[STAGES-1];
    assign out_0     = lane_res[0];
    assign out_1     = lane_res[1];

endmodule

// File: rtl/mstar_butterfly_chk.sv
// Module: mstar_butterfly_chk
// Port-level properties of the butterfly, attached by bind.
// Assumes: fixed latency of three cycles; corrections are never negative.
module mstar_butterfly_chk #(
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_full_mode,
    input logic signed [W-1:0] metric_a,
    input logic signed [W-1:0] metric_b,
    input logic signed [W-1:0] branch,
    input logic                out_valid,
    input logic signed [W-1:0] out_0,
    input logic signed [W-1:0] out_1
);

    logic [1:0] since_rst;

    // Count edges since reset, saturating at three
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // Clamped plain maximum for one lane
    function automatic logic signed [W-1:0] plain_max(
        input logic signed [W-1:0] a,
        input logic signed [W-1:0] b,
        input logic signed [W-1:0] x,
        input logic                lane
    );
        logic signed [W:0] p;
        logic signed [W:0] q;
        logic signed [W:0] m;
        p = lane ? ({b[W-1], b} + {x[W-1], x}) : ({a[W-1], a} + {x[W-1], x});
        q = lane ? ({a[W-1], a} - {x[W-1], x}) : ({b[W-1], b} - {x[W-1], x});
        m = (p > q) ? p : q;
        if (m > $signed({2'b00, {(W-1){1'b1}}})) begin
            return {1'b0, {(W-1){1'b1}}};
        end
        return m[W-1:0];
    endfunction

    // R1: output valid follows input valid by exactly three edges
    a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R2: lane 0 never falls below its plain maximum
    a_r2_out0_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && since_rst == 2'd3) |->
        (out_0 >= plain_max($past(metric_a, 3), $past(metric_b, 3), $past(branch, 3), 1'b0)));

    // R3: lane 1 never falls below its plain maximum
    a_r3_out1_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && since_rst == 2'd3) |->
        (out_1 >= plain_max($past(metric_a, 3), $past(metric_b, 3), $past(branch, 3), 1'b1)));

    // R6: max-log beats equal the plain maximum on both lanes
    a_r6_maxlog_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && since_rst == 2'd3 && !$past(in_full_mode, 3)) |->
        ((out_0 == plain_max($past(metric_a, 3), $past(metric_b, 3), $past(branch, 3), 1'b0)) &&
         (out_1 == plain_max($past(metric_a, 3), $past(metric_b, 3), $past(branch, 3), 1'b1))));

endmodule

bind mstar_butterfly mstar_butterfly_chk #(.W(METRIC_W)) i_mstar_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_full_mode (in_full_mode),
    .metric_a     (metric_a),
    .metric_b     (metric_b),
    .branch       (branch),
    .out_valid    (out_valid),
    .out_0        (out_0),
    .out_1        (out_1)
);

// File: tb/test_mstar_butterfly.sv
// Bench: directed corners plus seeded random beats, checked at the
// negative edge against a reference model written from the requirements.
module test_mstar_butterfly;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               in_full_mode = 1'b0;
    logic signed [15:0] metric_a = '0;
    logic signed [15:0] metric_b = '0;
    logic signed [15:0] branch = '0;
    logic               out_valid;
    logic signed [15:0] out_0;
    logic signed [15:0] out_1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Expected beats: index 2 is the one due at the current negedge
    bit    hv [3];
    int    he0 [3];
    int    he1 [3];
    string ht [3];

    always #5 clk = ~clk;

    mstar_butterfly i_mstar_butterfly (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_full_mode (in_full_mode),
        .metric_a     (metric_a),
        .metric_b     (metric_b),
        .branch       (branch),
        .out_valid    (out_valid),
        .out_0        (out_0),
        .out_1        (out_1)
    );

    // Correction in 1/8 units for a gap, per R4/R5
    function automatic int corr_of(int gap);
        case (gap / 4)
            0: return 6;
            1: return 4;
            2: return 3;
            3: return 2;
            4: return 1;
            5: return 1;
            default: return 0;
        endcase
    endfunction

    // Reference max-star with clamp, per R4/R6/R7
    function automatic int ref_mstar(int p, int q, bit full);
        int mx  = (p > q) ? p : q;
        int gap = (p > q) ? p - q : q - p;
        int r   = mx + (full ? corr_of(gap) : 0);
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic clear_hist();
        for (int i = 0; i < 3; i++) begin
            hv[i] = 1'b0; he0[i] = 0; he1[i] = 0; ht[i] = "";
        end
    endtask

    // Compare outputs with the beat due now
    task automatic check_out();
        checks++;
        if (out_valid !== hv[2]) begin
            fails++;
            $display("FAIL R1 out_valid got %0b exp %0b", out_valid, hv[2]);
        end
        if (hv[2] && out_valid === 1'b1) begin
            checks++;
            if (int'(out_0) != he0[2]) begin
                fails++;
                $display("FAIL R2 %s out_0 got %0d exp %0d", ht[2], out_0, he0[2]);
            end
            checks++;
            if (int'(out_1) != he1[2]) begin
                fails++;
                $display("FAIL R3 %s out_1 got %0d exp %0d", ht[2], out_1, he1[2]);
            end
        end
    endtask

    // One cycle: check due beat, then present a new one
    task automatic step(bit v, int a, int b, int x, bit full, string tag);
        @(negedge clk);
        check_out();
        for (int i = 2; i > 0; i--) begin
            hv[i] = hv[i-1]; he0[i] = he0[i-1]; he1[i] = he1[i-1]; ht[i] = ht[i-1];
        end
        hv[0]  = v;
        he0[0] = ref_mstar(a + x, b - x, full);
        he1[0] = ref_mstar(b + x, a - x, full);
        ht[0]  = tag;
        in_valid     = v;
        metric_a     = 16'(a);
        metric_b     = 16'(b);
        branch       = 16'(x);
        in_full_mode = full;
    endtask

    task automatic drain();
        for (int i = 0; i < 4; i++) step(1'b0, 0, 0, 0, 1'b0, "idle");
    endtask

    // Watchdog: a hung run counts as a failure and still summarises
    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd24681);
        clear_hist();
        repeat (3) @(negedge clk);
        // R8: reset state
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R8 out_valid in reset got %0b exp 0", out_valid);
        end
        rst_n = 1'b1;

        // R10: equal candidates take T[0]; R6: same beat without correction
        step(1'b1, 0, 0, 0, 1'b1, "R10");
        step(1'b1, 0, 0, 0, 1'b0, "R6");
        step(1'b1, 100, 100, 0, 1'b1, "R10");
        // R4: interior table entries
        step(1'b1, 5, 0, 0, 1'b1, "R4");
        step(1'b1, -9, 3, 2, 1'b1, "R4");
        // R5: table edge and far gaps
        step(1'b1, 23, 0, 0, 1'b1, "R5");
        step(1'b1, 24, 0, 0, 1'b1, "R5");
        step(1'b1, 1000, -2000, 7, 1'b1, "R5");
        // R7: clamp from candidate size and from the correction alone
        step(1'b1, 32767, 32767, 32767, 1'b1, "R7");
        step(1'b1, 32767, 32767, 0, 1'b1, "R7");
        step(1'b1, 32767, -32768, 32767, 1'b0, "R7");
        // R9: back-to-back beats with alternating modes
        for (int i = 0; i < 6; i++) step(1'b1, 3, 0, 0, i[0], "R9");
        // R1: gaps with changing inputs produce no beat
        step(1'b0, 1234, -77, 99, 1'b1, "R1");
        step(1'b0, -5, 5, 5, 1'b0, "R1");
        step(1'b1, -40, 12, -3, 1'b1, "R1");
        drain();

        // R8: reset while beats are in flight discards them
        step(1'b1, 10, 20, 30, 1'b1, "R8");
        step(1'b1, 11, 21, 31, 1'b1, "R8");
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        clear_hist();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0) begin
                fails++;
                $display("FAIL R8 flushed beat appeared got %0b exp 0", out_valid);
            end
        end

        // Random beats: small metrics inside the table, then full range
        for (int i = 0; i < 1500; i++) begin
            bit v   = ($urandom_range(3) != 0);
            bit md  = $urandom_range(1) != 0;
            int a, b, x;
            if ($urandom_range(1) != 0) begin
                a = int'($urandom_range(80)) - 40;
                b = int'($urandom_range(80)) - 40;
                x = int'($urandom_range(30)) - 15;
            end else begin
                a = int'($urandom_range(65535)) - 32768;
                b = int'($urandom_range(65535)) - 32768;
                x = int'($urandom_range(65535)) - 32768;
            end
            step(v, a, b, x, md, "R2R3");
        end
        drain();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule